// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers level-sensitive interrupt requests from 40 primary sources and from a secondary group of 32 sources. It merges them into one interrupt line to the processor. Each source has a pending bit and an enable bit. Software sets enable bits through one address and clears them through another, and it acknowledges pending bits by writing ones. The whole secondary group is folded into primary channel 0. A secondary source that is both pending and enabled acts as the request input of channel 0, alongside the raw primary input 0.

Software first reads the priority index. If the index is non-zero, it names the primary channel to serve. If it is zero, software checks the secondary status word. A bank of per-channel mapping registers is also provided. Each holds a channel number that software may rewrite. The register port is a plain 32-bit read/write port. Reads are combinational from the address, and a write takes effect at the clock edge where the strobe is high.

Top module: `intc_cascade_top`

## Requirements
- R1: After reset, every pending and enable bit is 0 and `irq_o` is low. The mapping register of channel n reads back n.
- R2: A primary source that is high at a clock edge sets its pending bit, which is visible after that edge. Channels 0..31 read at 0x010 and channels 32..39 read at 0x014 in bits 7:0, and the upper bits of 0x014 read 0.
- R3: Writing a 1 at 0x010 or 0x014 clears that channel's pending bit, and 0 bits leave it unchanged. If the source is still high at that edge, the bit stays set.
- R4: Writing a 1 at 0x020 or 0x024 sets that channel's enable bit, and 0 bits have no effect. Bits above channel 39 are ignored. The enable mask reads back at both 0x020/0x024 and 0x030/0x034.
- R5: Writing a 1 at 0x030 or 0x034 clears that channel's enable bit, and 0 bits have no effect.
- R6: `irq_o` is high exactly when some primary channel, channel 0 included, is both pending and enabled. A pending bit whose enable is 0 does not raise the line but stays pending.
- R7: Address 0x040 returns, in bits 5:0, the lowest channel number in 1..39 that is both pending and enabled. It returns 0 when no such channel exists, and its upper bits are 0.
- R8: Secondary group registers: 0x088 reads the raw pending bits, and a 1 written there clears the bit (the source wins at the same edge). A 1 written at 0x090 sets an enable and a 1 at 0x098 clears one, and both addresses read the enable mask. 0x080 reads pending AND enabled.
- R9: When any secondary source is pending and enabled at an edge, primary channel 0 becomes pending after that edge. Primary input 0 also feeds channel 0.
- R10: Channel n's mapping register is at 0x200 + 4*n. It stores the low 6 bits of a write, and its upper read bits are 0.
- R11: Addresses not listed here read 0, and a write to them changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prim_src_i | input | 40 | Primary level-sensitive request inputs |
| sec_src_i | input | 32 | Secondary group request inputs |
| bus_addr_i | input | 12 | Register byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
On every cycle, the assertions check the following:
- pending bits capture high sources and are never lost without a clear;
- enable bits move only under set or clear writes;
- the interrupt line matches the active set;
- the priority index points at an active channel and never skips an active one;
- an active secondary source reaches channel 0 one edge later.

The bench scenarios show the rest: the address map and read-back values, the upper-bank bit trimming, a source that re-asserts through an acknowledge, mapping register storage, and unmapped addresses having no effect. A behavioural model, compared each cycle under random stimulus, covers the interleavings.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned BUS_W  = 32;

  // primary banks: word offset (channel/32)*4 added to these bases
  localparam logic [ADDR_W-1:0] A_PEND   = 12'h010;
  localparam logic [ADDR_W-1:0] A_ENSET  = 12'h020;
  localparam logic [ADDR_W-1:0] A_ENCLR  = 12'h030;
  localparam logic [ADDR_W-1:0] A_PRIO   = 12'h040;
  // secondary group (single word)
  localparam logic [ADDR_W-1:0] A_SSTAT  = 12'h080;
  localparam logic [ADDR_W-1:0] A_SPEND  = 12'h088;
  localparam logic [ADDR_W-1:0] A_SENSET = 12'h090;
  localparam logic [ADDR_W-1:0] A_SENCLR = 12'h098;
  // mapping file
  localparam logic [ADDR_W-1:0] A_MAP    = 12'h200;

  function automatic int unsigned words_for(input int unsigned n);
    return (n + BUS_W - 1) / BUS_W;
  endfunction
endpackage

// File: rtl/intc_src_bank.sv
`timescale 1ns/1ps
module intc_src_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] clr_mask_i,
  input  logic [N-1:0] set_mask_i,
  input  logic [N-1:0] dis_mask_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] act_o
);
  logic [N-1:0] pend_q, en_q;

  // a source still high wins over an acknowledge at the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask_i) | src_i;
      en_q   <= (en_q | set_mask_i) & ~dis_mask_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign act_o  = pend_q & en_q;
endmodule

// File: rtl/intc_prio_pick.sv
`timescale 1ns/1ps
module intc_prio_pick #(
  parameter int unsigned N     = 40,
  parameter int unsigned IDX_W = 6
) (
  input  logic [N-1:0]     act_i,
  output logic [IDX_W-1:0] idx_o
);
  // lowest active channel number above 0; 0 when none
  function automatic logic [IDX_W-1:0] lowest_above_zero(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 1; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign idx_o = lowest_above_zero(act_i);
endmodule

// File: rtl/intc_chan_map.sv
`timescale 1ns/1ps
module intc_chan_map #(
  parameter int unsigned N = 40,
  parameter int unsigned W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N-1:0]       we_i,
  input  logic [W-1:0]       wdata_i,
  output logic [N-1:0][W-1:0] map_o
);
  logic [N-1:0][W-1:0] map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N); i++) map_q[i] <= W'(i);
    end else begin
      for (int i = 0; i < int'(N); i++) begin
        if (we_i[i]) map_q[i] <= wdata_i;
      end
    end
  end

  assign map_o = map_q;
endmodule

// File: rtl/intc_cascade_top.sv
`timescale 1ns/1ps
module intc_cascade_top
  import intc_pkg::*;
#(
  parameter int unsigned NPRI  = 40,
  parameter int unsigned NSEC  = 32,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned MAP_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPRI-1:0]   prim_src_i,
  input  logic [NSEC-1:0]   sec_src_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              irq_o
);
  localparam int unsigned NPW  = words_for(NPRI);
  localparam int unsigned WIDE = NPW * BUS_W;

  // ---- arithmetic helpers -------------------------------------------------
  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base, input int w);
    return base + ADDR_W'(4 * w);
  endfunction

  function automatic logic [NPRI-1:0] spread(input logic [NPW-1:0] we, input logic [BUS_W-1:0] d);
    logic [WIDE-1:0] wide;
    wide = '0;
    for (int w = 0; w < int'(NPW); w++) begin
      if (we[w]) wide[w*BUS_W +: BUS_W] = d;
    end
    return wide[NPRI-1:0];
  endfunction

  function automatic logic [BUS_W-1:0] word_of(input logic [NPRI-1:0] v, input int w);
    logic [WIDE-1:0] wide;
    wide = '0;
    wide[NPRI-1:0] = v;
    return wide[w*BUS_W +: BUS_W];
  endfunction

  // ---- named internal events ------------------------------------------------
  logic [NPW-1:0]  pclr_we, pset_we, pdis_we;
  logic [NPRI-1:0] pclr_mask, pset_mask, pdis_mask;
  logic [NSEC-1:0] sclr_mask, sset_mask, sdis_mask;
  logic [NPRI-1:0] map_we;
  logic [NPRI-1:0] pri_src, ppend, pen, pact;
  logic [NSEC-1:0] spend, sen, sact;
  logic            sec_any;
  logic [IDX_W-1:0] prio_idx;
  logic [NPRI-1:0][MAP_W-1:0] map_q;

  // ---- write decode ---------------------------------------------------------
  always_comb begin
    for (int w = 0; w < int'(NPW); w++) begin
      pclr_we[w] = bus_wr_i && (bus_addr_i == word_addr(A_PEND,  w));
      pset_we[w] = bus_wr_i && (bus_addr_i == word_addr(A_ENSET, w));
      pdis_we[w] = bus_wr_i && (bus_addr_i == word_addr(A_ENCLR, w));
    end
    for (int n = 0; n < int'(NPRI); n++) begin
      map_we[n] = bus_wr_i && (bus_addr_i == word_addr(A_MAP, n));
    end
  end

  assign pclr_mask = spread(pclr_we, bus_wdata_i);
  assign pset_mask = spread(pset_we, bus_wdata_i);
  assign pdis_mask = spread(pdis_we, bus_wdata_i);

  assign sclr_mask = (bus_wr_i && bus_addr_i == A_SPEND)  ? bus_wdata_i[NSEC-1:0] : '0;
  assign sset_mask = (bus_wr_i && bus_addr_i == A_SENSET) ? bus_wdata_i[NSEC-1:0] : '0;
  assign sdis_mask = (bus_wr_i && bus_addr_i == A_SENCLR) ? bus_wdata_i[NSEC-1:0] : '0;

  // ---- secondary group and cascade into channel 0 ---------------------------
  intc_src_bank #(.N(NSEC)) u_sec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (sec_src_i),
    .clr_mask_i (sclr_mask),
    .set_mask_i (sset_mask),
    .dis_mask_i (sdis_mask),
    .pend_o     (spend),
    .en_o       (sen),
    .act_o      (sact)
  );

  assign sec_any = |sact;
  assign pri_src = prim_src_i | {{(NPRI-1){1'b0}}, sec_any};

  intc_src_bank #(.N(NPRI)) u_pri (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (pri_src),
    .clr_mask_i (pclr_mask),
    .set_mask_i (pset_mask),
    .dis_mask_i (pdis_mask),
    .pend_o     (ppend),
    .en_o       (pen),
    .act_o      (pact)
  );

  intc_prio_pick #(.N(NPRI), .IDX_W(IDX_W)) u_prio (
    .act_i (pact),
    .idx_o (prio_idx)
  );

  intc_chan_map #(.N(NPRI), .W(MAP_W)) u_map (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (map_we),
    .wdata_i (bus_wdata_i[MAP_W-1:0]),
    .map_o   (map_q)
  );

  assign irq_o = |pact;

  // ---- read mux -------------------------------------------------------------
  always_comb begin
    bus_rdata_o = '0;
    for (int w = 0; w < int'(NPW); w++) begin
      if (bus_addr_i == word_addr(A_PEND, w))
        bus_rdata_o = word_of(ppend, w);
      if (bus_addr_i == word_addr(A_ENSET, w) || bus_addr_i == word_addr(A_ENCLR, w))
        bus_rdata_o = word_of(pen, w);
    end
    if (bus_addr_i == A_PRIO)   bus_rdata_o = BUS_W'(prio_idx);
    if (bus_addr_i == A_SSTAT)  bus_rdata_o = BUS_W'(sact);
    if (bus_addr_i == A_SPEND)  bus_rdata_o = BUS_W'(spend);
    if (bus_addr_i == A_SENSET || bus_addr_i == A_SENCLR) bus_rdata_o = BUS_W'(sen);
    for (int n = 0; n < int'(NPRI); n++) begin
      if (bus_addr_i == word_addr(A_MAP, n)) bus_rdata_o = BUS_W'(map_q[n]);
    end
  end
endmodule

// File: rtl/intc_cascade_chk.sv
`timescale 1ns/1ps
module intc_cascade_chk #(
  parameter int unsigned NPRI  = 40,
  parameter int unsigned NSEC  = 32,
  parameter int unsigned IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NPRI-1:0]  pri_src,
  input logic [NPRI-1:0]  ppend,
  input logic [NPRI-1:0]  pen,
  input logic [NPRI-1:0]  pclr_mask,
  input logic [NPRI-1:0]  pset_mask,
  input logic [NPRI-1:0]  pdis_mask,
  input logic [NSEC-1:0]  sec_src,
  input logic [NSEC-1:0]  spend,
  input logic             sec_any,
  input logic [IDX_W-1:0] prio_idx,
  input logic             irq_o
);
  // one cycle of history since reset before $past is trusted
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  logic [NPRI-1:0] active;
  assign active = ppend & pen;

  AST_PEND_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |=> (($past(pri_src) & ~ppend) == '0)); // R2
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |=> (($past(ppend) & ~$past(pclr_mask) & ~ppend) == '0)); // R3
  AST_PEND_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |=> (($past(pclr_mask) & ~$past(pri_src) & ppend) == '0)); // R3
  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |=> (($past(pset_mask) & ~pen) == '0)); // R4
  AST_EN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && pset_mask == '0 && pdis_mask == '0) |=> $stable(pen)); // R4
  AST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |=> (($past(pdis_mask) & pen) == '0)); // R5
  AST_IRQ_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (active != '0)); // R6
  AST_PRIO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio_idx != '0) |-> active[prio_idx]); // R7
  AST_PRIO_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio_idx == '0) |-> ((active >> 1) == '0)); // R7
  AST_PRIO_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio_idx > IDX_W'(1)) |-> ((active & ((NPRI'(1) << prio_idx) - NPRI'(2))) == '0)); // R7
  AST_SEC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |=> (($past(sec_src) & ~spend) == '0)); // R8
  AST_CASCADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && sec_any) |=> ppend[0]); // R9
endmodule

bind intc_cascade_top intc_cascade_chk #(.NPRI(NPRI), .NSEC(NSEC), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pri_src   (pri_src),
  .ppend     (ppend),
  .pen       (pen),
  .pclr_mask (pclr_mask),
  .pset_mask (pset_mask),
  .pdis_mask (pdis_mask),
  .sec_src   (sec_src_i),
  .spend     (spend),
  .sec_any   (sec_any),
  .prio_idx  (prio_idx),
  .irq_o     (irq_o)
);

// File: tb/intc_cascade_top_tb.sv
`timescale 1ns/1ps
module intc_cascade_top_tb;
  localparam int NP = 40;
  localparam int NS = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NP-1:0] prim_src = '0;
  logic [NS-1:0] sec_src = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int nchecks = 0;
  int errors  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  intc_cascade_top u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .prim_src_i  (prim_src),
    .sec_src_i   (sec_src),
    .bus_addr_i  (bus_addr),
    .bus_wr_i    (bus_wr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .irq_o       (irq)
  );

  // ---------------- behavioural reference model ----------------
  bit [NP-1:0] m_pp, m_pe;
  bit [NS-1:0] m_sp, m_se;
  int          m_map [NP];

  function automatic int m_lowest();
    for (int i = 1; i < NP; i++) if (m_pp[i] && m_pe[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    bit [63:0] p, e;
    p = 64'(m_pp); e = 64'(m_pe);
    case (a)
      12'h010: return p[31:0];
      12'h014: return p[63:32];
      12'h020, 12'h030: return e[31:0];
      12'h024, 12'h034: return e[63:32];
      12'h040: return 32'(m_lowest());
      12'h080: return m_sp & m_se;
      12'h088: return m_sp;
      12'h090, 12'h098: return m_se;
      default: begin
        if (a >= 12'h200 && a < 12'h200 + 12'(4*NP) && a[1:0] == 2'b00)
          return 32'(m_map[(a - 12'h200) >> 2] & 63);
        return 32'h0;
      end
    endcase
  endfunction

  function automatic string req_of(input logic [11:0] a);
    if (a == 12'h010 || a == 12'h014) return "R3";
    if (a == 12'h020 || a == 12'h024) return "R4";
    if (a == 12'h030 || a == 12'h034) return "R5";
    if (a == 12'h040) return "R7";
    if (a >= 12'h080 && a <= 12'h098) return "R8";
    if (a >= 12'h200 && a < 12'h2A0) return "R10";
    return "R11";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pp = '0; m_pe = '0; m_sp = '0; m_se = '0;
      for (int i = 0; i < NP; i++) m_map[i] = i;
    end else begin
      bit [63:0] pc, ps, pd;
      bit [NS-1:0] sc, ss, sd;
      bit [NP-1:0] src;
      pc = '0; ps = '0; pd = '0; sc = '0; ss = '0; sd = '0;
      src = prim_src;
      if ((m_sp & m_se) != '0) src[0] = 1'b1;
      if (bus_wr) begin
        case (bus_addr)
          12'h010: pc[31:0]  = bus_wdata;
          12'h014: pc[63:32] = bus_wdata;
          12'h020: ps[31:0]  = bus_wdata;
          12'h024: ps[63:32] = bus_wdata;
          12'h030: pd[31:0]  = bus_wdata;
          12'h034: pd[63:32] = bus_wdata;
          12'h088: sc = bus_wdata;
          12'h090: ss = bus_wdata;
          12'h098: sd = bus_wdata;
          default: if (bus_addr >= 12'h200 && bus_addr < 12'h2A0 && bus_addr[1:0] == 2'b00)
                     m_map[(bus_addr - 12'h200) >> 2] = int'(bus_wdata[5:0]);
        endcase
      end
      m_sp = (m_sp & ~sc) | sec_src;
      m_se = (m_se | ss) & ~sd;
      m_pp = (m_pp & ~pc[NP-1:0]) | src;
      m_pe = (m_pe | ps[NP-1:0]) & ~pd[NP-1:0];
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchecks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h (t=%0t)", req, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6", 32'(irq), 32'((m_pp & m_pe) != '0));
      check(req_of(bus_addr), bus_rdata, m_read(bus_addr));
    end
  end

  // ---------------- stimulus tasks (start and end at posedge + 1) ----------
  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a;
    @(negedge clk);
    check(req, bus_rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic irq_is(input string req, input logic exp);
    @(negedge clk);
    check(req, 32'(irq), 32'(exp));
    @(posedge clk); #1;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      nchecks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, nchecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);

    // R1 reset state
    irq_is("R1", 1'b0);
    rd("R1", 12'h010, 32'h0);
    rd("R1", 12'h020, 32'h0);
    rd("R1", 12'h088, 32'h0);
    rd("R1", 12'h090, 32'h0);
    rd("R1", 12'h200, 32'd0);
    rd("R1", 12'h204, 32'd1);
    rd("R1", 12'h29C, 32'd39);

    // R2 capture in both banks
    prim_src = (NP'(1) << 5) | (NP'(1) << 35);
    idle(1);
    prim_src = '0;
    rd("R2", 12'h010, 32'h0000_0020);
    rd("R2", 12'h014, 32'h0000_0008);
    irq_is("R6", 1'b0);                      // pending but not enabled

    // R4 enable set and read-back
    wr(12'h020, 32'h0000_0020);
    rd("R4", 12'h020, 32'h0000_0020);
    rd("R4", 12'h030, 32'h0000_0020);
    irq_is("R6", 1'b1);
    rd("R7", 12'h040, 32'd5);
    wr(12'h024, 32'hFFFF_FF08);
    rd("R4", 12'h024, 32'h0000_0008);
    wr(12'h020, 32'h0);
    rd("R4", 12'h020, 32'h0000_0020);
    rd("R7", 12'h040, 32'd5);

    // R3 acknowledge
    wr(12'h010, 32'h0000_0020);
    rd("R3", 12'h010, 32'h0);
    rd("R7", 12'h040, 32'd35);
    wr(12'h014, 32'h0);
    rd("R3", 12'h014, 32'h0000_0008);
    prim_src = NP'(1) << 35;
    idle(1);
    wr(12'h014, 32'h0000_0008);
    rd("R3", 12'h014, 32'h0000_0008);        // still high: re-pends
    prim_src = '0;
    idle(1);
    wr(12'h014, 32'h0000_0008);
    rd("R3", 12'h014, 32'h0);
    irq_is("R6", 1'b0);
    rd("R7", 12'h040, 32'd0);

    // R5 enable clear
    wr(12'h034, 32'h0000_0008);
    rd("R5", 12'h024, 32'h0);
    rd("R5", 12'h020, 32'h0000_0020);
    wr(12'h030, 32'h0000_0020);
    rd("R5", 12'h020, 32'h0);

    // R8 / R9 secondary group and cascade
    sec_src = NS'(1) << 7;
    idle(1);
    sec_src = '0;
    rd("R8", 12'h088, 32'h0000_0080);
    rd("R8", 12'h080, 32'h0);
    rd("R9", 12'h010, 32'h0);                // disabled: no cascade
    wr(12'h090, 32'h0000_0080);
    rd("R8", 12'h090, 32'h0000_0080);
    rd("R8", 12'h080, 32'h0000_0080);
    rd("R9", 12'h010, 32'h0000_0001);
    rd("R7", 12'h040, 32'd0);                // channel 0 excluded
    irq_is("R6", 1'b0);
    wr(12'h020, 32'h0000_0001);
    irq_is("R9", 1'b1);
    wr(12'h088, 32'h0000_0080);
    rd("R8", 12'h088, 32'h0);
    wr(12'h010, 32'h0000_0001);
    rd("R3", 12'h010, 32'h0);
    irq_is("R6", 1'b0);
    wr(12'h098, 32'h0000_0080);
    rd("R8", 12'h098, 32'h0);
    prim_src = NP'(1);
    idle(1);
    prim_src = '0;
    irq_is("R9", 1'b1);                      // raw input 0 feeds channel 0
    wr(12'h010, 32'h0000_0001);

    // R11 unmapped
    wr(12'h060, 32'hFFFF_FFFF);
    wr(12'h1FC, 32'hFFFF_FFFF);
    rd("R11", 12'h020, 32'h0000_0001);
    rd("R11", 12'h060, 32'h0);
    rd("R11", 12'h2A0, 32'h0);

    // R10 mapping registers
    wr(12'h208, 32'hFFFF_FFFF);
    rd("R10", 12'h208, 32'h0000_003F);
    wr(12'h29C, 32'h0000_0015);
    rd("R10", 12'h29C, 32'h0000_0015);
    rd("R10", 12'h20C, 32'd3);

    // random traffic, compared every cycle against the model
    for (int k = 0; k < 3000; k++) begin
      logic [11:0] a;
      int sel;
      prim_src = NP'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      sec_src  = NS'($urandom & $urandom & $urandom);
      sel = int'($urandom_range(0, 13));
      case (sel)
        0: a = 12'h010;  1: a = 12'h014;  2: a = 12'h020;  3: a = 12'h024;
        4: a = 12'h030;  5: a = 12'h034;  6: a = 12'h040;  7: a = 12'h080;
        8: a = 12'h088;  9: a = 12'h090; 10: a = 12'h098; 11: a = 12'h060;
        default: a = 12'h200 + 12'(4 * $urandom_range(0, NP - 1));
      endcase
      bus_addr  = a;
      bus_wdata = $urandom;
      bus_wr    = ($urandom_range(0, 2) == 0);
      @(posedge clk); #1;
    end
    bus_wr = 1'b0;
    prim_src = '0;
    sec_src = '0;
    idle(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, nchecks);
    $finish;
  end
endmodule